// File: doc/BRIEF.md
# Selectable Video Test Pattern Generator

This block sits on a pixel stream between a sensor front end and a downstream processing chain. A 3-bit selector picks the source of every output pixel. It can pass the sensor data through unchanged, or it can replace the data with one of five synthetic images. These are a static horizontal ramp, uniform white, uniform mid-grey, uniform black, and a vertical ramp that shifts by one level on every frame. The synthetic images help isolate faults on the link to a capture device, because their content is known in advance.

The upstream timing is a pixel-valid strobe plus line-start and frame-start markers. Each marker is qualified by valid and travels on the first beat of its line or frame. The block delays this timing by exactly one register stage and puts it on its output unchanged. A static depth input chooses between 8-bit and 12-bit pixels, and the uniform levels and ramp wrap points follow that choice. A new selector code takes effect only on a frame-start beat, so no frame ever mixes two sources. While a pattern is active, a bypass output tells the downstream chain to switch its processing off.

Top module: `video_tpg`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid`, `out_bypass` and `sel_rd` are all 0.
- R2: One cycle after a write (`sel_wr` high), `sel_rd` returns the raw 3-bit code that was written, including codes 6 and 7.
- R3: With code 0 active, every output pixel equals the input pixel of the previous cycle, bit for bit.
- R4: A written code becomes active on the next accepted frame-start beat (`in_valid` and `in_frame_start` both high) and applies from that beat on. A write during a frame does not change that frame's pixels, and a write in the same cycle as a frame-start beat waits for the following frame.
- R5: Code 1 outputs the pixel index within the line, modulo 2^D. The index is 0 on the line-start beat and increments on each valid beat. D is 8 or 12 according to the depth input.
- R6: Code 2 outputs 255 at 8-bit depth and 4095 at 12-bit depth.
- R7: Code 3 outputs 128 at 8-bit depth and 2048 at 12-bit depth.
- R8: Code 4 outputs 0 at both depths.
- R9: Code 5 outputs (line index + frame offset) modulo 2^D. The line index is 0 on the frame-start beat and increments on each line-start beat. The frame offset is the number of frame starts since reset minus one.
- R10: `out_bypass` is 1 exactly when the code in force for the corresponding input cycle is in the range 1 to 5.
- R11: An active code of 6 or 7 behaves exactly like code 0: pass-through, with bypass low.
- R12: `out_valid`, `out_line_start` and `out_frame_start` equal `in_valid`, `in_valid & in_line_start` and `in_valid & in_frame_start` of the previous cycle.
- R13: At 8-bit depth, every generated pixel has bits 11 to 8 equal to 0. Depth is sampled per beat (`depth_12` = 1 selects 12 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_wdata | input | 3 | Selector code to write |
| sel_rd | output | 3 | Last written selector code |
| depth_12 | input | 1 | 1: 12-bit pixels, 0: 8-bit pixels |
| in_valid | input | 1 | Input pixel valid |
| in_line_start | input | 1 | First beat of a line |
| in_frame_start | input | 1 | First beat of a frame |
| in_pixel | input | 12 | Sensor pixel |
| out_valid | output | 1 | Output pixel valid |
| out_line_start | output | 1 | Delayed line marker |
| out_frame_start | output | 1 | Delayed frame marker |
| out_pixel | output | 12 | Selected pixel |
| out_bypass | output | 1 | Downstream processing disable |

## Verification
Every pixel result, marker and bypass level appears on the ports exactly one clock after the input beat that caused it. The selector readback appears one clock after the write. The bench drives each beat on a falling edge and computes that beat's expected outputs from its own model of the selector, counters and frame offset. It then waits for the next falling edge, so exactly one rising edge has passed, and compares there. Writes that land in the middle of a frame or on a frame-start beat move only the model's pending code, so a premature switch shows up as a mismatch within the same frame.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    SRC_SENSOR = 3'd0,
    PAT_HRAMP  = 3'd1,
    PAT_WHITE  = 3'd2,
    PAT_GREY   = 3'd3,
    PAT_BLACK  = 3'd4,
    PAT_VRAMP  = 3'd5
  } tpg_code_e;

  // Codes above the table fall back to the sensor path.
  function automatic tpg_code_e tpg_norm(input logic [2:0] raw);
    if (raw > 3'd5) return SRC_SENSOR;
    return tpg_code_e'(raw);
  endfunction

endpackage

// File: rtl/tpg_sel_ctrl.sv
module tpg_sel_ctrl
  import tpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic [2:0] wr_code,
  input  logic      frame_beat,
  output logic [2:0] rd_code,
  output tpg_code_e eff_code
);

  logic [2:0] pend_q;
  tpg_code_e  act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 3'd0;
      act_q  <= SRC_SENSOR;
    end else begin
      if (wr_en)      pend_q <= wr_code;
      if (frame_beat) act_q  <= tpg_norm(pend_q);
    end
  end

  // On the frame-start beat the pending code already governs that beat.
  always_comb eff_code = frame_beat ? tpg_norm(pend_q) : act_q;
  assign rd_code = pend_q;

  // R2: readback reflects the last write one cycle later
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_code == $past(wr_code));

  // R4: the active code never moves outside a frame-start beat
  a_r4_hold_midframe: assert property (@(posedge clk) disable iff (rst)
    !frame_beat |=> $stable(act_q));

  // R11: codes 6 and 7 never become active
  a_r11_legal_active: assert property (@(posedge clk) disable iff (rst)
    act_q <= PAT_VRAMP);

endmodule

// File: rtl/tpg_coord.sv
module tpg_coord #(
  parameter int X_W = 12,
  parameter int Y_W = 12,
  parameter int F_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           beat,
  input  logic           line_mark,
  input  logic           frame_mark,
  output logic [X_W-1:0] cur_x,
  output logic [Y_W-1:0] cur_y,
  output logic [F_W-1:0] cur_off
);

  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;
  logic [F_W-1:0] next_off_q;
  logic [F_W-1:0] frame_off_q;

  always_comb begin
    cur_x   = (line_mark || frame_mark) ? '0 : x_q;
    if (frame_mark)     cur_y = '0;
    else if (line_mark) cur_y = y_q + 1'b1;
    else                cur_y = y_q;
    cur_off = frame_mark ? next_off_q : frame_off_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q         <= '0;
      y_q         <= '0;
      next_off_q  <= '0;
      frame_off_q <= '0;
    end else if (beat) begin
      x_q <= cur_x + 1'b1;
      y_q <= cur_y;
      if (frame_mark) begin
        frame_off_q <= next_off_q;
        next_off_q  <= next_off_q + 1'b1;
      end
    end
  end

  // R5: a line-start beat restarts the pixel count at one for the next beat
  a_r5_x_restart: assert property (@(posedge clk) disable iff (rst)
    (beat && line_mark) |=> x_q == X_W'(1));

  // R9: the frame offset is constant within a frame
  a_r9_offset_hold: assert property (@(posedge clk) disable iff (rst)
    !(beat && frame_mark) |=> $stable(frame_off_q));

endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
  import tpg_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int NARROW_W = 8,
  parameter int X_W      = 12,
  parameter int Y_W      = 12,
  parameter int F_W      = 12
) (
  input  tpg_code_e        code,
  input  logic             wide,
  input  logic [X_W-1:0]   cur_x,
  input  logic [Y_W-1:0]   cur_y,
  input  logic [F_W-1:0]   cur_off,
  input  logic [PIX_W-1:0] sensor,
  output logic [PIX_W-1:0] value
);

  logic [PIX_W-1:0] depth_mask;
  logic [PIX_W-1:0] mid_level;
  logic [PIX_W-1:0] h_ramp;
  logic [PIX_W-1:0] v_ramp;

  for (genvar g = 0; g < PIX_W; g++) begin : g_mask
    if (g < NARROW_W) begin : g_low
      assign depth_mask[g] = 1'b1;
    end else begin : g_high
      assign depth_mask[g] = wide;
    end
  end

  always_comb begin
    mid_level = wide ? (PIX_W'(1) << (PIX_W - 1)) : (PIX_W'(1) << (NARROW_W - 1));
    h_ramp    = PIX_W'(cur_x) & depth_mask;
    v_ramp    = (PIX_W'(cur_y) + PIX_W'(cur_off)) & depth_mask;
    case (code)
      PAT_HRAMP: value = h_ramp;
      PAT_WHITE: value = depth_mask;
      PAT_GREY:  value = mid_level;
      PAT_BLACK: value = '0;
      PAT_VRAMP: value = v_ramp;
      default:   value = sensor;
    endcase
  end

endmodule

// File: rtl/video_tpg.sv
module video_tpg
  import tpg_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int NARROW_W = 8,
  parameter int X_W      = 12,
  parameter int Y_W      = 12,
  parameter int F_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [2:0]       sel_wdata,
  output logic [2:0]       sel_rd,
  input  logic             depth_12,
  input  logic             in_valid,
  input  logic             in_line_start,
  input  logic             in_frame_start,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  output logic             out_line_start,
  output logic             out_frame_start,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_bypass
);

  localparam int HIGH_W = PIX_W - NARROW_W;

  logic             frame_beat;
  logic             line_beat;
  tpg_code_e        eff_code;
  logic [X_W-1:0]   cur_x;
  logic [Y_W-1:0]   cur_y;
  logic [F_W-1:0]   cur_off;
  logic [PIX_W-1:0] gen_value;

  assign frame_beat = in_valid && in_frame_start;
  assign line_beat  = in_valid && in_line_start;

  tpg_sel_ctrl u_sel (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (sel_wr),
    .wr_code    (sel_wdata),
    .frame_beat (frame_beat),
    .rd_code    (sel_rd),
    .eff_code   (eff_code)
  );

  tpg_coord #(.X_W(X_W), .Y_W(Y_W), .F_W(F_W)) u_coord (
    .clk        (clk),
    .rst        (rst),
    .beat       (in_valid),
    .line_mark  (line_beat),
    .frame_mark (frame_beat),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .cur_off    (cur_off)
  );

  tpg_pattern #(
    .PIX_W(PIX_W), .NARROW_W(NARROW_W), .X_W(X_W), .Y_W(Y_W), .F_W(F_W)
  ) u_pat (
    .code    (eff_code),
    .wide    (depth_12),
    .cur_x   (cur_x),
    .cur_y   (cur_y),
    .cur_off (cur_off),
    .sensor  (in_pixel),
    .value   (gen_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_line_start  <= 1'b0;
      out_frame_start <= 1'b0;
      out_pixel       <= '0;
      out_bypass      <= 1'b0;
    end else begin
      out_valid       <= in_valid;
      out_line_start  <= line_beat;
      out_frame_start <= frame_beat;
      out_pixel       <= gen_value;
      out_bypass      <= (eff_code != SRC_SENSOR);
    end
  end

  // R12: output timing follows the input by one stage
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: without bypass the pixel is the sensor pixel of the previous cycle
  a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bypass) |-> out_pixel == $past(in_pixel));

  // R13: narrow depth leaves the upper bits of generated pixels clear
  a_r13_narrow_depth: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bypass && !$past(depth_12)) |-> out_pixel[PIX_W-1 -: HIGH_W] == '0);

endmodule

// File: tb/test_video_tpg.sv
module test_video_tpg;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel_wr;
  logic [2:0]  sel_wdata;
  logic [2:0]  sel_rd;
  logic        depth_12;
  logic        in_valid, in_line_start, in_frame_start;
  logic [11:0] in_pixel;
  logic        out_valid, out_line_start, out_frame_start;
  logic [11:0] out_pixel;
  logic        out_bypass;

  always #10 clk = ~clk;

  video_tpg i_video_tpg (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_rd(sel_rd),
    .depth_12(depth_12), .in_valid(in_valid), .in_line_start(in_line_start),
    .in_frame_start(in_frame_start), .in_pixel(in_pixel), .out_valid(out_valid),
    .out_line_start(out_line_start), .out_frame_start(out_frame_start),
    .out_pixel(out_pixel), .out_bypass(out_bypass)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int m_pend = 0, m_act = 0, m_x = 0, m_y = 0, m_noff = 0, m_foff = 0;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int norm(int c);
    return (c > 5) ? 0 : c;
  endfunction

  function automatic string code_req(int raw);
    case (raw)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      6, 7: return "R11";
      default: return "R3";
    endcase
  endfunction

  function automatic int exp_pixel(int c, bit wide, int x, int y, int off, int pin);
    int mask = wide ? 4095 : 255;
    case (c)
      1: return x & mask;
      2: return mask;
      3: return wide ? 2048 : 128;
      4: return 0;
      5: return (y + off) & mask;
      default: return pin;
    endcase
  endfunction

  // Drive one beat at a falling edge, check its results at the next falling edge.
  task automatic beat(bit v, bit ls, bit fs, bit wr, int wcode, string extra);
    int pin = int'($urandom_range(0, 4095));
    int eff, raw, cx, cy, coff, exp_pix;
    in_valid = v; in_line_start = ls; in_frame_start = fs; in_pixel = 12'(pin);
    sel_wr = wr; sel_wdata = 3'(wcode);
    raw = (v && fs) ? m_pend : -1;
    eff = (v && fs) ? norm(m_pend) : m_act;
    exp_pix = 0;
    if (v) begin
      cx   = (ls || fs) ? 0 : m_x;
      cy   = fs ? 0 : (ls ? ((m_y + 1) & 4095) : m_y);
      coff = fs ? m_noff : m_foff;
      m_x  = (cx + 1) & 4095;
      m_y  = cy;
      if (fs) begin
        m_foff = m_noff;
        m_noff = (m_noff + 1) & 4095;
        m_act  = eff;
      end
      exp_pix = exp_pixel(eff, depth_12, cx, cy, coff, pin);
    end
    if (wr) m_pend = wcode;
    @(negedge clk);
    check("R12 valid", int'(out_valid), int'(v));
    check("R10 bypass", int'(out_bypass), int'(eff != 0));
    if (v) begin
      check("R12 line marker", int'(out_line_start), int'(ls));
      check("R12 frame marker", int'(out_frame_start), int'(fs));
      check($sformatf("%s%s pixel", (raw >= 0) ? code_req(raw) : code_req(eff), extra),
            int'(out_pixel), exp_pix);
      if (!depth_12 && eff != 0) check("R13 high bits", int'(out_pixel[11:8]), 0);
    end
    if (wr) check("R2 readback", int'(sel_rd), wcode);
  endtask

  task automatic idle_write(int code);
    beat(0, 0, 0, 1, code, "");
  endtask

  // One frame; optional write at (wl, 1) or on the frame-start beat (wl = -2).
  task automatic frame(int nl, int np, int gap_pct, int wl, int wcode);
    string extra = (wl != -1) ? "/R4" : "";
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < np; p++) begin
        bit wr;
        if (int'($urandom_range(0, 99)) < gap_pct) beat(0, 0, 0, 0, 0, extra);
        wr = (wl == l && p == 1) || (wl == -2 && l == 0 && p == 0);
        beat(1, p == 0, l == 0 && p == 0, wr, wcode, extra);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; sel_wr = 0; sel_wdata = 0; depth_12 = 1;
    in_valid = 0; in_line_start = 0; in_frame_start = 0; in_pixel = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 bypass in reset", int'(out_bypass), 0);
    check("R1 readback in reset", int'(sel_rd), 0);
    rst = 0;
    @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 bypass after reset", int'(out_bypass), 0);
    check("R1 readback after reset", int'(sel_rd), 0);

    // every code at 12-bit depth
    for (int c = 0; c < 8; c++) begin
      idle_write(c);
      frame(4, 24, 20, -1, 0);
    end
    // 8-bit depth
    depth_12 = 0;
    for (int c = 1; c < 6; c++) begin
      idle_write(c);
      frame(3, 20, 10, -1, 0);
    end
    // R4: mid-frame write waits for the next frame
    idle_write(2);
    frame(3, 16, 0, 1, 4);
    frame(2, 16, 0, -1, 0);
    // R4: write on a frame-start beat applies one frame later
    frame(2, 8, 0, -2, 3);
    frame(2, 8, 0, -1, 0);
    // R5 wrap at 8 bits
    idle_write(1);
    frame(1, 300, 0, -1, 0);
    // R9 wrap at 8 bits
    idle_write(5);
    frame(300, 2, 0, -1, 0);
    frame(3, 2, 0, -1, 0);
    // random mix
    for (int f = 0; f < 40; f++) begin
      depth_12 = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) idle_write(int'($urandom_range(0, 7)));
      frame(int'($urandom_range(1, 6)), int'($urandom_range(1, 30)), 25,
            ($urandom_range(0, 3) == 0) ? 0 : -1, int'($urandom_range(0, 7)));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule